// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the general registers and the status registers of a 32-bit processor core that runs in one of seven operating modes. Sixteen register numbers (0 to 15) are visible at any time. Number 15 is the program counter. Depending on the current mode, some register numbers reach a private physical copy instead of the shared one. The fast-interrupt mode has private copies of registers 8 to 14. The normal-interrupt, supervisor, abort and undefined modes each have private copies of 13 and 14 only. User and system modes share the base set. In total the block holds 31 general registers and 6 status registers.

The block has two registered read ports and one write port. It also has a write path for the current status word, a write path for the saved status word of the current mode, and an exception-entry request. An exception entry does three things in one cycle. It saves the current status word into the target mode's saved copy. It puts the return address into that mode's register 14. It switches the mode and clears the 16-bit-state bit. While the 16-bit instruction state is active, only registers 0 to 7, 13, 14 and 15 are reachable.

Top module: `banked_regfile`

## Requirements
- R1: After reset, the current status word is 0x000000D3 (supervisor mode, both interrupt-disable bits set, 32-bit state). Both read outputs are zero. The saved-status output is zero and `mode_err` is low.
- R2: Reads are registered. The value of the register named by `rd_a_idx`/`rd_b_idx` at a rising edge appears on `rd_a_data`/`rd_b_data` after that edge. Register writes take effect at the edge.
- R3: When a read names the same register as a write in the same cycle, the read output after that edge shows the newly written value. A write to a different register does not affect the read.
- R4: The mode (status bits 4:0) selects the bank. Fast-interrupt mode (10001) uses private registers 8 to 14. Normal-interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes use private registers 13 and 14. User (10000) and system (11111) modes share the base registers, and every mode shares registers 0 to 7 and 15.
- R5: A read of register 15 returns the stored value with bits 1:0 cleared in 32-bit state (status bit 5 = 0), or with bit 0 cleared in 16-bit state (status bit 5 = 1).
- R6: In 16-bit state, register numbers 8 to 12 read as zero and writes to them are ignored. Numbers 13, 14 and 15 still reach the current mode's stack pointer, link register and program counter.
- R7: A status write updates only bits 31:28 and 7:0. Bits 27:8 keep their value.
- R8: A status write whose mode field is not one of the seven legal encodings is rejected as a whole. An exception request that names a mode other than the five exception modes is also rejected. In both cases `mode_err` is high for the cycle after the request, and no register changes.
- R9: A legal exception entry copies the current status word into the target mode's saved status word and writes `exc_ret` into the target mode's register 14. It sets the mode field to `exc_mode`, clears bit 5, and keeps every other status bit. In that cycle, register, status and saved-status writes are dropped.
- R10: `spsr_q` shows the saved status word of the current mode, and a saved-status write updates only its bits 31:28 and 7:0. In user and system modes, `spsr_q` is zero and saved-status writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data (registered) |
| rd_b_idx | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data (registered) |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write number |
| wr_data | input | 32 | Register write data |
| psr_wr_en | input | 1 | Current status word write enable |
| psr_wr_data | input | 32 | Current status word write data |
| spsr_wr_en | input | 1 | Saved status word write enable (current mode) |
| spsr_wr_data | input | 32 | Saved status word write data |
| exc_en | input | 1 | Exception entry request |
| exc_mode | input | 5 | Target mode of the exception |
| exc_ret | input | 32 | Return address for the target mode's register 14 |
| cpsr_q | output | 32 | Current status word |
| spsr_q | output | 32 | Saved status word of the current mode |
| mode_err | output | 1 | Pulse after a rejected mode encoding |

## Verification
The same register numbers are written and read in user, system, fast-interrupt, supervisor and normal-interrupt modes. This separates shared copies from private copies: a value written in user mode must show up in system mode but not in supervisor mode. Same-cycle write/read pairs on the same number and on different numbers separate the bypass path from stale storage reads. Register 15 is read in both instruction states, which shows the two masking rules. Registers 8 to 12 are probed in 16-bit state and then read again in 32-bit state to show that the ignored write left them intact. An exception entry is issued together with a conflicting register write, and illegal mode codes are sent on both paths, to show the priority and the rejection rules.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [3:0]    rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          psr_wr_en,
  input  logic [DW-1:0] psr_wr_data,
  input  logic          spsr_wr_en,
  input  logic [DW-1:0] spsr_wr_data,
  input  logic          exc_en,
  input  logic [4:0]    exc_mode,
  input  logic [DW-1:0] exc_ret,
  output logic [DW-1:0] cpsr_q,
  output logic [DW-1:0] spsr_q,
  output logic          mode_err
);

  localparam int NPHYS = 31;
  localparam int NSAVE = 5;
  localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                         M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011,
                         M_SYS = 5'b11111;
  localparam logic [DW-1:0] CPSR_RST = DW'(32'h0000_00D3);
  localparam logic [DW-1:0] DEF_MASK = {4'hF, {(DW-12){1'b0}}, 8'hFF};

  logic [DW-1:0] rf [NPHYS];
  logic [DW-1:0] sv [NSAVE];
  logic [DW-1:0] cpsr;

  function automatic logic mode_ok(input logic [4:0] m);
    return m inside {M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS};
  endfunction

  function automatic logic exc_ok(input logic [4:0] m);
    return m inside {M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND};
  endfunction

  function automatic logic [2:0] slot(input logic [4:0] m);
    case (m)
      M_FIQ:   return 3'd0;
      M_IRQ:   return 3'd1;
      M_SVC:   return 3'd2;
      M_ABT:   return 3'd3;
      M_UND:   return 3'd4;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [4:0] phys(input logic [4:0] m, input logic [3:0] i);
    logic [2:0] s;
    s = slot(m);
    if (s == 3'd0 && i >= 4'd8 && i <= 4'd14) return 5'(i) + 5'd8;
    if (s != 3'd7 && s != 3'd0 && i >= 4'd13 && i <= 4'd14)
      return 5'd23 + 5'({s - 3'd1, 1'b0}) + 5'(i == 4'd14);
    return 5'(i);
  endfunction

  logic [4:0] mode;
  logic       tbit;
  assign mode = cpsr[4:0];
  assign tbit = cpsr[5];

  function automatic logic hidden(input logic t, input logic [3:0] i);
    return t && i >= 4'd8 && i <= 4'd12;
  endfunction

  logic       exc_go, psr_bad, exc_bad, psr_go, wr_go, sv_go;
  logic [4:0] wr_p, rda_p, rdb_p, lr_p;
  logic [2:0] cur_slot, exc_slot;

  assign exc_go   = exc_en && exc_ok(exc_mode);
  assign exc_bad  = exc_en && !exc_ok(exc_mode);
  assign psr_bad  = psr_wr_en && !exc_go && !mode_ok(psr_wr_data[4:0]);
  assign psr_go   = psr_wr_en && !exc_go && mode_ok(psr_wr_data[4:0]);
  assign wr_go    = wr_en && !exc_go && !hidden(tbit, wr_idx);
  assign cur_slot = slot(mode);
  assign exc_slot = slot(exc_mode);
  assign sv_go    = spsr_wr_en && !exc_go && cur_slot != 3'd7;
  assign wr_p     = phys(mode, wr_idx);
  assign rda_p    = phys(mode, rd_a_idx);
  assign rdb_p    = phys(mode, rd_b_idx);
  assign lr_p     = phys(exc_mode, 4'd14);

  function automatic logic [DW-1:0] view(input logic [DW-1:0] v, input logic [3:0] i,
                                         input logic t);
    if (hidden(t, i)) return '0;
    if (i == 4'd15) return t ? {v[DW-1:1], 1'b0} : {v[DW-1:2], 2'b00};
    return v;
  endfunction

  logic [DW-1:0] rda_raw, rdb_raw;
  assign rda_raw = (wr_go && wr_p == rda_p) ? wr_data : rf[rda_p];
  assign rdb_raw = (wr_go && wr_p == rdb_p) ? wr_data : rf[rdb_p];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NPHYS; k++) rf[k] <= '0;
      for (int k = 0; k < NSAVE; k++) sv[k] <= '0;
      cpsr      <= CPSR_RST;
      rd_a_data <= '0;
      rd_b_data <= '0;
      mode_err  <= 1'b0;
    end else begin
      rd_a_data <= view(rda_raw, rd_a_idx, tbit);
      rd_b_data <= view(rdb_raw, rd_b_idx, tbit);
      mode_err  <= psr_bad || exc_bad;
      if (exc_go) begin
        rf[lr_p]     <= exc_ret;
        sv[exc_slot] <= cpsr;
        cpsr         <= {cpsr[DW-1:6], 1'b0, exc_mode};
      end else begin
        if (wr_go) rf[wr_p] <= wr_data;
        if (psr_go) cpsr <= (psr_wr_data & DEF_MASK) | (cpsr & ~DEF_MASK);
        if (sv_go) sv[cur_slot] <= (spsr_wr_data & DEF_MASK) | (sv[cur_slot] & ~DEF_MASK);
      end
    end
  end

  assign cpsr_q = cpsr;
  assign spsr_q = (cur_slot == 3'd7) ? '0 : sv[cur_slot];

  a_r8_mode_always_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ok(cpsr_q[4:0]));

  a_r7_reserved_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cpsr_q[DW-5:8]));

  a_r8_bad_psr_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_wr_en && !mode_ok(psr_wr_data[4:0]) && !(exc_en && exc_ok(exc_mode)))
      |=> ($stable(cpsr_q) && mode_err));

  a_r9_entry_mode_state: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_en && exc_ok(exc_mode))
      |=> (cpsr_q[4:0] == $past(exc_mode) && !cpsr_q[5]
           && cpsr_q[DW-1:6] == $past(cpsr_q[DW-1:6])));

  a_r9_entry_saves_status: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_en && exc_ok(exc_mode)) |=> (spsr_q == $past(cpsr_q)));

  a_r10_no_saved_in_user: assert property (@(posedge clk) disable iff (!rst_n)
    (cpsr_q[4:0] == M_USR || cpsr_q[4:0] == M_SYS) |-> (spsr_q == '0));

endmodule

// File: tb/test_banked_regfile.sv
module test_banked_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, psr_wr_en = 1'b0, spsr_wr_en = 1'b0, exc_en = 1'b0;
  logic [31:0] psr_wr_data = '0, spsr_wr_data = '0, exc_ret = '0;
  logic [4:0]  exc_mode = '0;
  logic [31:0] cpsr_q, spsr_q;
  logic        mode_err;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  banked_regfile i_banked_regfile (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .psr_wr_en(psr_wr_en), .psr_wr_data(psr_wr_data),
    .spsr_wr_en(spsr_wr_en), .spsr_wr_data(spsr_wr_data),
    .exc_en(exc_en), .exc_mode(exc_mode), .exc_ret(exc_ret),
    .cpsr_q(cpsr_q), .spsr_q(spsr_q), .mode_err(mode_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] i, input logic [31:0] d);
    wr_en = 1'b1; wr_idx = i; wr_data = d; tick; wr_en = 1'b0;
  endtask

  task automatic set_psr(input logic [31:0] d);
    psr_wr_en = 1'b1; psr_wr_data = d; tick; psr_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] i, output logic [31:0] a, output logic [31:0] b);
    rd_a_idx = i; rd_b_idx = i; tick; a = rd_a_data; b = rd_b_data;
  endtask

  task automatic t_reset;
    chk("R1 cpsr", cpsr_q, 32'hD3);
    chk("R1 rd_a", rd_a_data, 0);
    chk("R1 rd_b", rd_b_data, 0);
    chk("R1 spsr", spsr_q, 0);
    chk("R1 mode_err", {31'b0, mode_err}, 0);
  endtask

  task automatic t_banks;
    logic [31:0] a, b;
    wr(0, 32'hA0); wr(8, 32'h88); wr(9, 32'h1009); wr(13, 32'h5D13); wr(14, 32'h5D14);
    set_psr(32'h10);
    wr(13, 32'h13); wr(14, 32'h14);
    rd(8, a, b); chk("R4 user sees shared r8", a, 32'h88); chk("R2 port b r8", b, 32'h88);
    set_psr(32'h1F);
    rd(13, a, b); chk("R4 system shares user r13", a, 32'h13);
    set_psr(32'hD1);
    wr(8, 32'hF8); wr(13, 32'hF13);
    rd(8, a, b); chk("R4 fiq private r8", a, 32'hF8);
    rd(0, a, b); chk("R4 fiq shares r0", a, 32'hA0);
    set_psr(32'hD3);
    rd(8, a, b); chk("R4 svc r8 untouched by fiq", a, 32'h88);
    rd(13, a, b); chk("R4 svc private r13", a, 32'h5D13);
    rd(14, a, b); chk("R4 svc private r14", b, 32'h5D14);
    set_psr(32'hD2);
    rd(13, a, b); chk("R4 irq private r13 empty", a, 0);
    set_psr(32'hD3);
  endtask

  task automatic t_bypass;
    rd_a_idx = 5; rd_b_idx = 5;
    wr_en = 1'b1; wr_idx = 5; wr_data = 32'h55; tick; wr_en = 1'b0;
    chk("R3 bypass port a", rd_a_data, 32'h55);
    chk("R3 bypass port b", rd_b_data, 32'h55);
    rd_a_idx = 4;
    wr_en = 1'b1; wr_idx = 3; wr_data = 32'h33; tick; wr_en = 1'b0;
    chk("R3 no bypass other index", rd_a_data, 0);
  endtask

  task automatic t_pc_thumb;
    logic [31:0] a, b;
    wr(15, 32'hFFFF_FFFF);
    rd(15, a, b); chk("R5 pc 32-bit state", a, 32'hFFFF_FFFC);
    set_psr(32'hF3);
    rd(15, a, b); chk("R5 pc 16-bit state", a, 32'hFFFF_FFFE);
    rd(9, a, b); chk("R6 r9 hidden in 16-bit", a, 0);
    wr(9, 32'hBAD);
    rd(13, a, b); chk("R6 sp reachable in 16-bit", a, 32'h5D13);
    set_psr(32'hD3);
    rd(9, a, b); chk("R6 write to hidden r9 ignored", a, 32'h1009);
  endtask

  task automatic t_psr_fields;
    set_psr(32'hFFFF_FFFF); chk("R7 defined bits only", cpsr_q, 32'hF000_00FF);
    set_psr(32'h0000_00D3); chk("R7 restore", cpsr_q, 32'hD3);
  endtask

  task automatic t_illegal;
    set_psr(32'h15);
    chk("R8 bad psr mode_err", {31'b0, mode_err}, 1);
    chk("R8 bad psr cpsr kept", cpsr_q, 32'hD3);
    tick;
    chk("R8 mode_err one pulse", {31'b0, mode_err}, 0);
    exc_en = 1'b1; exc_mode = 5'h10; exc_ret = 32'h777; tick; exc_en = 1'b0;
    chk("R8 bad exc mode_err", {31'b0, mode_err}, 1);
    chk("R8 bad exc cpsr kept", cpsr_q, 32'hD3);
  endtask

  task automatic t_exception;
    logic [31:0] a, b;
    set_psr(32'h8000_0030);
    chk("R10 user spsr zero", spsr_q, 0);
    spsr_wr_en = 1'b1; spsr_wr_data = 32'hFFFF_FFFF; tick; spsr_wr_en = 1'b0;
    chk("R10 user spsr write ignored", spsr_q, 0);
    exc_en = 1'b1; exc_mode = 5'h12; exc_ret = 32'h1234;
    wr_en = 1'b1; wr_idx = 0; wr_data = 32'hDEAD;
    tick; exc_en = 1'b0; wr_en = 1'b0;
    chk("R9 cpsr after entry", cpsr_q, 32'h8000_0012);
    chk("R9 saved status", spsr_q, 32'h8000_0030);
    rd(14, a, b); chk("R9 return address in irq r14", a, 32'h1234);
    rd(0, a, b); chk("R9 concurrent write dropped", a, 32'hA0);
    spsr_wr_en = 1'b1; spsr_wr_data = 32'hFFFF_FFFF; tick; spsr_wr_en = 1'b0;
    chk("R10 irq spsr write", spsr_q, 32'hF000_00FF);
    set_psr(32'h10);
    rd(14, a, b); chk("R9 user r14 untouched", a, 32'h14);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_banks;
    t_bypass;
    t_pc_thumb;
    t_psr_fields;
    t_illegal;
    t_exception;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule